// File: doc/BRIEF.md
# Trap Entry and Vectoring Unit

This block performs the hardware steps of trap entry in a 64-bit core with register windows. Each cycle it picks at most one trap source: an explicit synchronous trap request that carries a 9-bit type, a misaligned memory access reported by the load/store path, or an external interrupt that carries a 4-bit level. Interrupts pass only when interrupts are enabled and their level is above the current interrupt level.

When a trap is accepted, the unit raises the trap level by one. At the new level it stores the condition codes, address space identifier, processor state word, window pointer, PC, nPC and trap type in a small indexed trap stack. It forces the processor state word to its trap-entry value and moves the window pointer for window traps. It then presents the handler's PC and nPC, formed from the trap base address.

The core supplies its current architectural state on input ports and takes the registered results when `taken_o` pulses. A trap that arrives when the stack is already full sends the unit into a sticky error mode. A synchronous read port gives the core access to any stack level.

Top module: `trap_vector_unit`

## Requirements
- R1: An accepted trap raises `taken_o` for exactly the cycle after the request, and `tl_o` increases by one at that same edge. Without an accepted trap, `taken_o` is 0 and `tl_o` holds its value.
- R2: An accepted trap writes to stack level `tl_o` (new value): the packed word {ccr[7:0], asi[7:0], pstate[9:0], cwp}, the PC, the nPC and the trap type. `rd_lvl_i` selects a level, and the `rd_*` outputs show it one cycle later. When a level is written and read in the same cycle, the read returns the contents from before that write.
- R3: `tt_o` holds the type of the last accepted trap.
- R4: The processor state word has these fields: bit 0 alternate globals, bit 1 interrupt enable, bit 2 privileged, bit 3 address mask, bit 4 FPU enable, bit 5 red state, bits 7:6 memory model, bit 8 trap little-endian, bit 9 current little-endian. On entry the alternate globals bit and the privileged bit become 1. The interrupt enable, address mask and red state bits become 0. The FPU enable bit becomes 1 only if the FPU parameter is set. The memory model and trap little-endian fields are kept, and the current little-endian bit copies the trap little-endian bit.
- R5: The new window pointer, taken modulo the window count, is: cwp+1 for type 0x024; cwp+cansave+2 for types 0x080–0x0BF; cwp−1 for types 0x0C0–0x0FF; cwp unchanged for any other type.
- R6: `new_pc_o` is {tba[63:15], (trap level was nonzero before entry), tt[8:0], 5'b00000}.
- R7: `new_npc_o` equals `new_pc_o` + 4.
- R8: When sources arrive in the same cycle, the explicit trap request wins over a misaligned access, and a misaligned access wins over an interrupt.
- R9: An interrupt is accepted only when pstate bit 1 is set and `irq_level_i` > `pil_i`. An accepted interrupt gets type 0x040 + level. Any other interrupt request has no effect.
- R10: Access size codes are 0 byte, 1 half-word, 2 word, 3 doubleword and 4 quad-word, which need alignment to 1, 2, 4, 8 and 16 bytes. A misaligned access raises type 0x034. Aligned accesses and size codes 5–7 raise nothing.
- R11: A trap accepted while `tl_o` equals MAXTL (default 5) sets `err_mode_o`, writes nothing to the stack and leaves `taken_o` low. `err_mode_o` then stays set until reset, and all requests are ignored.
- R12: Synchronous active-high reset clears `tl_o`, `err_mode_o`, `taken_o` and all registered result and read outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trap_req_i | input | 1 | Explicit synchronous trap request |
| trap_type_i | input | 9 | Type of the explicit trap |
| irq_req_i | input | 1 | External interrupt request |
| irq_level_i | input | 4 | Interrupt level, 15 highest |
| pil_i | input | 4 | Current processor interrupt level |
| mem_req_i | input | 1 | Memory access being issued |
| mem_size_i | input | 3 | Access size code |
| mem_addr_lo_i | input | 4 | Low address bits of the access |
| pstate_i | input | 10 | Current processor state word |
| cwp_i | input | CW | Current window pointer |
| cansave_i | input | CW | Savable-window count |
| ccr_i | input | 8 | Condition codes |
| asi_i | input | 8 | Address space identifier |
| pc_i | input | VA_W | Current PC |
| npc_i | input | VA_W | Current nPC |
| tba_hi_i | input | VA_W-15 | Trap base address bits 63:15 |
| rd_lvl_i | input | TLW | Stack level to read |
| taken_o | output | 1 | Trap entered this cycle |
| tt_o | output | 9 | Type of the last trap |
| new_pc_o | output | VA_W | Handler PC |
| new_npc_o | output | VA_W | Handler nPC |
| new_pstate_o | output | 10 | Processor state word at trap entry |
| new_cwp_o | output | CW | Window pointer at trap entry |
| tl_o | output | TLW | Current trap level |
| err_mode_o | output | 1 | Sticky error mode |
| rd_tstate_o | output | 16+10+CW | Packed state word at the read level |
| rd_tpc_o | output | VA_W | Saved PC at the read level |
| rd_tnpc_o | output | VA_W | Saved nPC at the read level |
| rd_tt_o | output | 9 | Saved trap type at the read level |

## Verification
Some properties are checked on every cycle:
- each entry steps the trap level by exactly one;
- the forced state-word fields;
- the nPC offset and the vector's low fields, including the nonzero-level bit;
- the clean-window pointer step;
- the interrupt gate when an interrupt is the only source;
- the error-mode bound and its stickiness.

Other behaviour shows only in the bench's scenarios, where a behavioural model is compared on every clock:
- the spill and fill window arithmetic with wraparound;
- the priority among simultaneous sources;
- each size code of the alignment check;
- the read-before-write order of the stack port;
- the values saved at each level.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int PS_W    = 10;
  localparam int TT_W    = 9;
  localparam int BYTE_W  = 8;
  localparam int LVL_W   = 4;
  localparam int VEC_LO  = 15;
  localparam int ALO_W   = 4;

  typedef struct packed {
    logic       cle;
    logic       tle;
    logic [1:0] mm;
    logic       red;
    logic       pef;
    logic       am;
    logic       priv;
    logic       ie;
    logic       ag;
  } pstate_t;

  typedef enum logic [2:0] {
    SZ_BYTE  = 3'd0,
    SZ_HALF  = 3'd1,
    SZ_WORD  = 3'd2,
    SZ_DWORD = 3'd3,
    SZ_QUAD  = 3'd4
  } acc_size_e;

  localparam logic [TT_W-1:0] TT_CLEAN_WIN = 9'h024;
  localparam logic [TT_W-1:0] TT_MISALIGN  = 9'h034;
  localparam logic [TT_W-1:0] TT_IRQ_BASE  = 9'h040;
  localparam logic [2:0]      TT_SPILL_TOP = 3'b010;
  localparam logic [2:0]      TT_FILL_TOP  = 3'b011;
endpackage

// File: rtl/trap_align_chk.sv
module trap_align_chk import trap_pkg::*; (
  input  logic             mem_req_i,
  input  logic [2:0]       mem_size_i,
  input  logic [ALO_W-1:0] addr_lo_i,
  output logic             misalign_o
);
  logic [ALO_W-1:0] mask;

  // Alignment mask: one low bit per doubling of the access size.
  always_comb begin
    mask = '0;
    for (int b = 0; b < ALO_W; b++) begin
      if (int'(mem_size_i) > b && mem_size_i <= SZ_QUAD) mask[b] = 1'b1;
    end
  end

  assign misalign_o = mem_req_i && ((addr_lo_i & mask) != '0);
endmodule

// File: rtl/trap_arbiter.sv
module trap_arbiter import trap_pkg::*; (
  input  logic             block_i,
  input  logic             trap_req_i,
  input  logic [TT_W-1:0]  trap_type_i,
  input  logic             misalign_i,
  input  logic             irq_req_i,
  input  logic [LVL_W-1:0] irq_level_i,
  input  logic [LVL_W-1:0] pil_i,
  input  logic             ie_i,
  output logic             fire_o,
  output logic [TT_W-1:0]  tt_o
);
  logic irq_ok;

  assign irq_ok = irq_req_i && ie_i && (irq_level_i > pil_i);

  always_comb begin
    fire_o = 1'b0;
    tt_o   = '0;
    if (!block_i) begin
      if (trap_req_i) begin
        fire_o = 1'b1;
        tt_o   = trap_type_i;
      end else if (misalign_i) begin
        fire_o = 1'b1;
        tt_o   = TT_MISALIGN;
      end else if (irq_ok) begin
        fire_o = 1'b1;
        tt_o   = TT_IRQ_BASE | TT_W'(irq_level_i);
      end
    end
  end
endmodule

// File: rtl/trap_entry_calc.sv
module trap_entry_calc import trap_pkg::*; #(
  parameter int VA_W    = 64,
  parameter int NWIN    = 8,
  parameter bit HAS_FPU = 1'b1,
  localparam int CW     = $clog2(NWIN)
)(
  input  logic [TT_W-1:0]       tt_i,
  input  logic [1:0]            mm_i,
  input  logic                  tle_i,
  input  logic [CW-1:0]         cwp_i,
  input  logic [CW-1:0]         cansave_i,
  input  logic [VA_W-1:VEC_LO]  tba_hi_i,
  input  logic                  tl_nz_i,
  output logic [VA_W-1:0]       pc_o,
  output logic [VA_W-1:0]       npc_o,
  output pstate_t               ps_o,
  output logic [CW-1:0]         cwp_o
);
  always_comb begin
    ps_o      = '0;
    ps_o.mm   = mm_i;
    ps_o.tle  = tle_i;
    ps_o.cle  = tle_i;
    ps_o.pef  = HAS_FPU;
    ps_o.priv = 1'b1;
    ps_o.ag   = 1'b1;
  end

  always_comb begin
    if (tt_i == TT_CLEAN_WIN)
      cwp_o = cwp_i + CW'(1);
    else if (tt_i[TT_W-1:TT_W-3] == TT_SPILL_TOP)
      cwp_o = cwp_i + cansave_i + CW'(2);
    else if (tt_i[TT_W-1:TT_W-3] == TT_FILL_TOP)
      cwp_o = cwp_i - CW'(1);
    else
      cwp_o = cwp_i;
  end

  assign pc_o  = {tba_hi_i, tl_nz_i, tt_i, 5'b00000};
  assign npc_o = {tba_hi_i, tl_nz_i, tt_i, 5'b00100};
endmodule

// File: rtl/trap_stack.sv
module trap_stack #(
  parameter int AW    = 3,
  parameter int ENT_W = 64,
  localparam int DEPTH = 1 << AW
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [ENT_W-1:0] wdata_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [ENT_W-1:0] rdata_o
);
  logic [ENT_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  // Read-first output register with synchronous reset.
  always_ff @(posedge clk) begin
    if (rst) rdata_o <= '0;
    else     rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/trap_vector_unit.sv
module trap_vector_unit import trap_pkg::*; #(
  parameter int VA_W    = 64,
  parameter int NWIN    = 8,
  parameter int MAXTL   = 5,
  parameter bit HAS_FPU = 1'b1,
  localparam int CW     = $clog2(NWIN),
  localparam int TLW    = $clog2(MAXTL + 1),
  localparam int TS_W   = 2 * BYTE_W + PS_W + CW
)(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 trap_req_i,
  input  logic [TT_W-1:0]      trap_type_i,
  input  logic                 irq_req_i,
  input  logic [LVL_W-1:0]     irq_level_i,
  input  logic [LVL_W-1:0]     pil_i,
  input  logic                 mem_req_i,
  input  logic [2:0]           mem_size_i,
  input  logic [ALO_W-1:0]     mem_addr_lo_i,
  input  logic [PS_W-1:0]      pstate_i,
  input  logic [CW-1:0]        cwp_i,
  input  logic [CW-1:0]        cansave_i,
  input  logic [BYTE_W-1:0]    ccr_i,
  input  logic [BYTE_W-1:0]    asi_i,
  input  logic [VA_W-1:0]      pc_i,
  input  logic [VA_W-1:0]      npc_i,
  input  logic [VA_W-1:VEC_LO] tba_hi_i,
  input  logic [TLW-1:0]       rd_lvl_i,
  output logic                 taken_o,
  output logic [TT_W-1:0]      tt_o,
  output logic [VA_W-1:0]      new_pc_o,
  output logic [VA_W-1:0]      new_npc_o,
  output logic [PS_W-1:0]      new_pstate_o,
  output logic [CW-1:0]        new_cwp_o,
  output logic [TLW-1:0]       tl_o,
  output logic                 err_mode_o,
  output logic [TS_W-1:0]      rd_tstate_o,
  output logic [VA_W-1:0]      rd_tpc_o,
  output logic [VA_W-1:0]      rd_tnpc_o,
  output logic [TT_W-1:0]      rd_tt_o
);
  localparam int ENT_W = TS_W + 2 * VA_W + TT_W;

  pstate_t         cur_ps;
  logic            misalign;
  logic            fire;
  logic [TT_W-1:0] sel_tt;
  logic            full;
  logic            push;
  logic [TLW-1:0]  tl_q;
  logic            err_q;
  logic [VA_W-1:0] calc_pc, calc_npc;
  pstate_t         calc_ps;
  logic [CW-1:0]   calc_cwp;
  logic [ENT_W-1:0] wr_ent, rd_ent;

  assign cur_ps = pstate_t'(pstate_i);

  trap_align_chk u_align (
    .mem_req_i  (mem_req_i),
    .mem_size_i (mem_size_i),
    .addr_lo_i  (mem_addr_lo_i),
    .misalign_o (misalign)
  );

  trap_arbiter u_arb (
    .block_i     (err_q),
    .trap_req_i  (trap_req_i),
    .trap_type_i (trap_type_i),
    .misalign_i  (misalign),
    .irq_req_i   (irq_req_i),
    .irq_level_i (irq_level_i),
    .pil_i       (pil_i),
    .ie_i        (cur_ps.ie),
    .fire_o      (fire),
    .tt_o        (sel_tt)
  );

  trap_entry_calc #(.VA_W(VA_W), .NWIN(NWIN), .HAS_FPU(HAS_FPU)) u_calc (
    .tt_i      (sel_tt),
    .mm_i      (cur_ps.mm),
    .tle_i     (cur_ps.tle),
    .cwp_i     (cwp_i),
    .cansave_i (cansave_i),
    .tba_hi_i  (tba_hi_i),
    .tl_nz_i   (tl_q != '0),
    .pc_o      (calc_pc),
    .npc_o     (calc_npc),
    .ps_o      (calc_ps),
    .cwp_o     (calc_cwp)
  );

  assign full   = (tl_q == TLW'(MAXTL));
  assign push   = fire && !full;
  assign wr_ent = {ccr_i, asi_i, pstate_i, cwp_i, pc_i, npc_i, sel_tt};

  trap_stack #(.AW(TLW), .ENT_W(ENT_W)) u_stack (
    .clk     (clk),
    .rst     (rst),
    .we_i    (push),
    .waddr_i (tl_q + TLW'(1)),
    .wdata_i (wr_ent),
    .raddr_i (rd_lvl_i),
    .rdata_o (rd_ent)
  );

  assign {rd_tstate_o, rd_tpc_o, rd_tnpc_o, rd_tt_o} = rd_ent;

  always_ff @(posedge clk) begin
    if (rst) begin
      tl_q         <= '0;
      err_q        <= 1'b0;
      taken_o      <= 1'b0;
      tt_o         <= '0;
      new_pc_o     <= '0;
      new_npc_o    <= '0;
      new_pstate_o <= '0;
      new_cwp_o    <= '0;
    end else begin
      taken_o <= push;
      if (fire && full) err_q <= 1'b1;
      if (push) begin
        tl_q         <= tl_q + TLW'(1);
        tt_o         <= sel_tt;
        new_pc_o     <= calc_pc;
        new_npc_o    <= calc_npc;
        new_pstate_o <= calc_ps;
        new_cwp_o    <= calc_cwp;
      end
    end
  end

  assign tl_o       = tl_q;
  assign err_mode_o = err_q;
endmodule

// File: rtl/trap_vector_unit_chk.sv
module trap_vector_unit_chk #(
  parameter int VA_W  = 64,
  parameter int MAXTL = 5,
  parameter int TLW   = 3,
  parameter int CW    = 3
)(
  input logic            clk,
  input logic            rst,
  input logic            trap_req_i,
  input logic            mem_req_i,
  input logic            irq_req_i,
  input logic [3:0]      irq_level_i,
  input logic [3:0]      pil_i,
  input logic [9:0]      pstate_i,
  input logic [CW-1:0]   cwp_i,
  input logic            taken_o,
  input logic [8:0]      tt_o,
  input logic [VA_W-1:0] new_pc_o,
  input logic [VA_W-1:0] new_npc_o,
  input logic [9:0]      new_pstate_o,
  input logic [CW-1:0]   new_cwp_o,
  input logic [TLW-1:0]  tl_o,
  input logic            err_mode_o
);
  AST_TL_STEP: assert property (@(posedge clk) disable iff (rst)
    taken_o |-> tl_o == TLW'($past(tl_o) + 1'b1)); // R1
  AST_TL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !taken_o |-> $stable(tl_o)); // R1
  AST_PS_FORCED: assert property (@(posedge clk) disable iff (rst)
    taken_o |-> (new_pstate_o[0] && !new_pstate_o[1] && new_pstate_o[2]
                 && !new_pstate_o[3] && !new_pstate_o[5])); // R4
  AST_PS_ENDIAN: assert property (@(posedge clk) disable iff (rst)
    taken_o |-> new_pstate_o[9] == new_pstate_o[8]); // R4
  AST_CLEAN_CWP: assert property (@(posedge clk) disable iff (rst)
    (taken_o && tt_o == 9'h024) |-> new_cwp_o == CW'($past(cwp_i) + 1'b1)); // R5
  AST_VEC_FIELDS: assert property (@(posedge clk) disable iff (rst)
    taken_o |-> (new_pc_o[4:0] == 5'd0 && new_pc_o[13:5] == tt_o
                 && new_pc_o[14] == ($past(tl_o) != '0))); // R6
  AST_NPC_STEP: assert property (@(posedge clk) disable iff (rst)
    taken_o |-> new_npc_o == new_pc_o + VA_W'(4)); // R7
  AST_IRQ_GATE: assert property (@(posedge clk) disable iff (rst)
    (taken_o && $past(!trap_req_i && !mem_req_i)) |->
      ($past(irq_req_i && pstate_i[1] && irq_level_i > pil_i)
       && tt_o == (9'h040 | 9'($past(irq_level_i))))); // R9
  AST_TL_BOUND: assert property (@(posedge clk) disable iff (rst)
    tl_o <= TLW'(MAXTL)); // R11
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    err_mode_o |=> err_mode_o); // R11
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (rst)
    err_mode_o |-> !taken_o); // R11
endmodule

bind trap_vector_unit trap_vector_unit_chk #(
  .VA_W(VA_W), .MAXTL(MAXTL), .TLW(TLW), .CW(CW)
) u_chk (
  .clk(clk), .rst(rst), .trap_req_i(trap_req_i), .mem_req_i(mem_req_i),
  .irq_req_i(irq_req_i), .irq_level_i(irq_level_i), .pil_i(pil_i),
  .pstate_i(pstate_i), .cwp_i(cwp_i), .taken_o(taken_o), .tt_o(tt_o),
  .new_pc_o(new_pc_o), .new_npc_o(new_npc_o), .new_pstate_o(new_pstate_o),
  .new_cwp_o(new_cwp_o), .tl_o(tl_o), .err_mode_o(err_mode_o)
);

// File: tb/trap_vector_unit_bench.sv
module trap_vector_unit_bench;
  localparam int MAXTL = 5;
  localparam int NWIN  = 8;
  localparam int CW    = 3;
  localparam int TLW   = 3;
  localparam int TS_W  = 29;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic trap_req_i = 0; logic [8:0] trap_type_i = '0;
  logic irq_req_i = 0;  logic [3:0] irq_level_i = '0; logic [3:0] pil_i = '0;
  logic mem_req_i = 0;  logic [2:0] mem_size_i = '0; logic [3:0] mem_addr_lo_i = '0;
  logic [9:0] pstate_i = '0;
  logic [CW-1:0] cwp_i = '0, cansave_i = '0;
  logic [7:0] ccr_i = '0, asi_i = '0;
  logic [63:0] pc_i = '0, npc_i = '0;
  logic [63:15] tba_hi_i = '0;
  logic [TLW-1:0] rd_lvl_i = '0;
  logic taken_o; logic [8:0] tt_o; logic [63:0] new_pc_o, new_npc_o;
  logic [9:0] new_pstate_o; logic [CW-1:0] new_cwp_o; logic [TLW-1:0] tl_o;
  logic err_mode_o; logic [TS_W-1:0] rd_tstate_o; logic [63:0] rd_tpc_o, rd_tnpc_o;
  logic [8:0] rd_tt_o;

  always #10 clk = ~clk;

  trap_vector_unit u_trap_vector_unit (.*);

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  // Behavioural reference state
  int m_tl; bit m_err; bit m_taken; logic [8:0] m_tt;
  logic [63:0] m_pc, m_npc; logic [9:0] m_ps; logic [CW-1:0] m_cwp;
  logic [TS_W-1:0] s_ts [8]; logic [63:0] s_pc [8], s_npc [8]; logic [8:0] s_tt [8];
  bit s_vld [8];
  bit r_vld; logic [TS_W-1:0] r_ts; logic [63:0] r_pc, r_npc; logic [8:0] r_tt;

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic model_edge();
    bit fire = 0; int t = 0; int w;
    int lvl = int'(rd_lvl_i);
    r_vld = s_vld[lvl]; r_ts = s_ts[lvl]; r_pc = s_pc[lvl]; r_npc = s_npc[lvl]; r_tt = s_tt[lvl];
    if (!m_err) begin
      if (trap_req_i) begin fire = 1; t = int'(trap_type_i); end
      else if (mem_req_i && mem_size_i <= 3'd4 &&
               (int'(mem_addr_lo_i) % (1 << int'(mem_size_i))) != 0) begin fire = 1; t = 'h34; end
      else if (irq_req_i && pstate_i[1] && irq_level_i > pil_i) begin fire = 1; t = 'h40 + int'(irq_level_i); end
    end
    m_taken = 0;
    if (fire) begin
      if (m_tl == MAXTL) m_err = 1;
      else begin
        m_tl = m_tl + 1;
        s_ts[m_tl] = {ccr_i, asi_i, pstate_i, cwp_i};
        s_pc[m_tl] = pc_i; s_npc[m_tl] = npc_i; s_tt[m_tl] = 9'(t); s_vld[m_tl] = 1;
        m_taken = 1; m_tt = 9'(t);
        m_pc  = {tba_hi_i, (m_tl > 1), 9'(t), 5'b0};
        m_npc = m_pc + 64'd4;
        m_ps = pstate_i;
        m_ps[0] = 1; m_ps[1] = 0; m_ps[2] = 1; m_ps[3] = 0; m_ps[4] = 1; m_ps[5] = 0;
        m_ps[9] = pstate_i[8];
        if (t == 'h24) w = int'(cwp_i) + 1;
        else if (t >= 'h80 && t <= 'hBF) w = int'(cwp_i) + int'(cansave_i) + 2;
        else if (t >= 'hC0 && t <= 'hFF) w = int'(cwp_i) + NWIN - 1;
        else w = int'(cwp_i);
        m_cwp = CW'(w % NWIN);
      end
    end
  endtask

  task automatic compare_all(input string tag);
    chk("R1", {tag, " taken"}, 64'(taken_o), 64'(m_taken));
    chk("R1", {tag, " tl"}, 64'(tl_o), 64'(m_tl));
    chk("R11", {tag, " err"}, 64'(err_mode_o), 64'(m_err));
    chk("R3", {tag, " tt"}, 64'(tt_o), 64'(m_tt));
    chk("R6", {tag, " pc"}, new_pc_o, m_pc);
    chk("R7", {tag, " npc"}, new_npc_o, m_npc);
    chk("R4", {tag, " pstate"}, 64'(new_pstate_o), 64'(m_ps));
    chk("R5", {tag, " cwp"}, 64'(new_cwp_o), 64'(m_cwp));
    if (r_vld) begin
      chk("R2", {tag, " rd_tstate"}, 64'(rd_tstate_o), 64'(r_ts));
      chk("R2", {tag, " rd_tpc"}, rd_tpc_o, r_pc);
      chk("R2", {tag, " rd_tnpc"}, rd_tnpc_o, r_npc);
      chk("R2", {tag, " rd_tt"}, 64'(rd_tt_o), 64'(r_tt));
    end
  endtask

  task automatic cycle(input string tag);
    model_edge();
    @(posedge clk);
    @(negedge clk);
    compare_all(tag);
    pc_i = pc_i + 64'h40; npc_i = pc_i + 64'd4;
    ccr_i = ccr_i + 8'h11; asi_i = asi_i ^ 8'h5A;
  endtask

  task automatic do_reset();
    rst = 1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    rst = 0;
    m_tl = 0; m_err = 0; m_taken = 0; m_tt = '0; m_pc = '0; m_npc = '0; m_ps = '0; m_cwp = '0;
    r_vld = 1; r_ts = '0; r_pc = '0; r_npc = '0; r_tt = '0;
    compare_all("R12 reset");
  endtask

  task automatic sync_trap(input logic [8:0] t, input string tag);
    trap_req_i = 1; trap_type_i = t;
    cycle(tag);
    trap_req_i = 0;
    cycle({tag, " idle"});
  endtask

  initial begin
    for (int i = 0; i < 8; i++) s_vld[i] = 0;
    tba_hi_i = 49'h1_FFFE_0000_2469;
    pc_i = 64'h0000_0000_0040_1000; npc_i = 64'h0000_0000_0040_1004;
    do_reset();
    pstate_i = 10'h1AA; cansave_i = 3'd3;
    // R5 clean window wraps 7 -> 0
    cwp_i = 3'd7; sync_trap(9'h024, "R5 clean");
    // R5 spill: 6+3+2 mod 8 = 3; R6 level bit now 1
    cwp_i = 3'd6; sync_trap(9'h085, "R5 spill");
    // R5 fill wraps 0 -> 7
    cwp_i = 3'd0; sync_trap(9'h0C3, "R5 fill");
    cwp_i = 3'd4; sync_trap(9'h010, "R5 other");
    // R2 readback of each level
    for (int l = 1; l <= 4; l++) begin rd_lvl_i = TLW'(l); cycle("R2 sweep"); end
    cycle("R2 sweep last");

    do_reset();
    pstate_i = 10'h1AA;
    // R9 level equal to pil ignored
    irq_req_i = 1; irq_level_i = 4'd5; pil_i = 4'd5; cycle("R9 equal");
    pil_i = 4'd4; cycle("R9 accept");
    irq_req_i = 0; cycle("R9 idle");
    // R9 disabled interrupts ignored
    pstate_i = 10'h1A8; irq_req_i = 1; irq_level_i = 4'd15; pil_i = 4'd0; cycle("R9 ie0");
    pstate_i = 10'h1AA; pil_i = 4'd14; cycle("R9 top level");
    irq_req_i = 0; cycle("R9 idle2");
    // R8 explicit trap beats interrupt
    irq_req_i = 1; irq_level_i = 4'd9; pil_i = 4'd1;
    trap_req_i = 1; trap_type_i = 9'h001; cycle("R8 trap vs irq");
    trap_req_i = 0; irq_req_i = 0; cycle("R8 idle");

    do_reset();
    pstate_i = 10'h0AA; rd_lvl_i = 3'd1;
    mem_req_i = 1; mem_size_i = 3'd2; mem_addr_lo_i = 4'h2; cycle("R10 word misalign");
    mem_size_i = 3'd4; mem_addr_lo_i = 4'h0; cycle("R10 quad aligned");
    mem_size_i = 3'd3; mem_addr_lo_i = 4'h8; cycle("R10 dword aligned");
    mem_size_i = 3'd1; mem_addr_lo_i = 4'h1; cycle("R10 half misalign");
    mem_size_i = 3'd5; mem_addr_lo_i = 4'h3; cycle("R10 size5");
    mem_size_i = 3'd0; mem_addr_lo_i = 4'hF; cycle("R10 byte");
    // R8 trap beats misalign, misalign beats interrupt
    mem_size_i = 3'd3; mem_addr_lo_i = 4'h4;
    trap_req_i = 1; trap_type_i = 9'h007; cycle("R8 trap vs mem");
    trap_req_i = 0; irq_req_i = 1; irq_level_i = 4'd12; pil_i = 4'd0; cycle("R8 mem vs irq");
    irq_req_i = 0; mem_req_i = 0; cycle("R8 idle");
    // R11 fill to MAXTL with same-cycle read of the written level (R2)
    rd_lvl_i = 3'd5; sync_trap(9'h0C8, "R11 fifth");
    sync_trap(9'h011, "R11 overflow");
    sync_trap(9'h012, "R11 ignored");
    irq_req_i = 1; irq_level_i = 4'd15; cycle("R11 irq ignored");
    irq_req_i = 0;
    for (int l = 0; l <= MAXTL; l++) begin rd_lvl_i = TLW'(l); cycle("R2 sweep2"); end
    cycle("R2 sweep2 last");
    do_reset();
    cycle("R12 after");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule